// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Core

This block is a small multicycle processor for a 16-bit word machine. It has eight 16-bit general registers and a program counter, and a single synchronous memory port addressed in words. It fetches one fixed-width 16-bit instruction per step. It decodes the instruction into an operation code and two register fields, then moves data between the registers and memory.

A fixed 16-bit instruction has no room for a full 16-bit constant. The core therefore offers two ways to put one into a register:

- An inline-immediate instruction takes the program word that follows it as the literal. It then steps the program counter past that word, so the literal is never executed.
- A PC-relative literal load reads a word that lies within a short signed distance of the code that uses it.

Register-indirect load and store complete the instruction set, and a halt instruction stops the machine. The memory port is a plain synchronous RAM interface with no handshake: an address presented in one cycle returns its word in the next. A debug select input reads any register combinationally, so a testbench can inspect state after a halt.

Top module: `lsc_core`

## Requirements
- R1: An instruction word carries its operation code in bits [15:10], register field A in [9:7] and register field B in [6:4]. Bits [3:0] have no effect on any instruction that uses two register fields.
- R2: While reset is low, all eight registers read as 0, `halted` is 0, `mem_we` is 0 and `mem_addr` is 0. After reset the first fetch is from address 0.
- R3: Operation code 110000 (load) reads memory at the address held in register A and writes the word into register B. When A and B name the same register, the loaded word replaces the address.
- R4: Operation code 110001 (store) writes the value of register A to memory at the address held in register B. `mem_we` is high for exactly one cycle per store, and no other word is written.
- R5: Operation code 110010 (inline immediate) writes the next program word into register A. Execution resumes at the word after that literal, even when the literal itself encodes an instruction.
- R6: Operation code 110011 (PC-relative load) takes bits [6:0] as a signed word offset from -64 to +63. It adds the offset to the address of the word that follows the instruction and loads the word at that address into register A.
- R7: Any operation code not listed in R3 to R6 or R8 does nothing except advance to the next word.
- R8: Operation code 111111 (halt) raises `halted`. From then until the next reset, `halted` stays high, `mem_addr` holds the address after the halt word, and `mem_we` stays low.
- R9: Memory reads have one cycle of latency. The program counter advances by exactly one word for each word fetched, whether that word is an instruction or an inline literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Word address to memory |
| mem_wdata | output | 16 | Store data to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Word read from memory, valid one cycle after its address |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_sel | input | 3 | Register index for debug read |
| dbg_data | output | 16 | Contents of the selected register |

## Verification
The assertions assume a memory that returns the addressed word exactly one cycle later. They also assume that `mem_rdata` is a defined value whenever the core is in a decode or write-back step. The bench models the memory as a synchronous array that is cleared before every program, so every fetch and every data read returns a defined word with that latency.

The bench sweeps every register pair for load and for store. It also sweeps all 128 PC-relative offsets across a padded program image, and it places an encoded halt inside an inline literal.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned NREGS  = 8;
  localparam int unsigned SEL_W  = $clog2(NREGS);
  localparam int unsigned OP_W   = 6;
  localparam int unsigned OFF_W  = 7;

  localparam logic [OP_W-1:0] OP_LOAD  = 6'b110000;
  localparam logic [OP_W-1:0] OP_STORE = 6'b110001;
  localparam logic [OP_W-1:0] OP_IMM   = 6'b110010;
  localparam logic [OP_W-1:0] OP_PCREL = 6'b110011;
  localparam logic [OP_W-1:0] OP_HALT  = 6'b111111;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_MEM, S_WB, S_HALT
  } step_e;
endpackage

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
  parameter int unsigned W = lsc_pkg::WORD_W,
  parameter int unsigned N = lsc_pkg::NREGS,
  localparam int unsigned SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] rd_sel_a,
  output logic [W-1:0]  rd_data_a,
  input  logic [SW-1:0] rd_sel_b,
  output logic [W-1:0]  rd_data_b,
  input  logic [SW-1:0] dbg_sel,
  output logic [W-1:0]  dbg_data
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                 regs[g] <= '0;
      else if (wr_en && wr_sel == SW'(g))         regs[g] <= wr_data;
    end
  end

  assign rd_data_a = regs[rd_sel_a];
  assign rd_data_b = regs[rd_sel_b];
  assign dbg_data  = regs[dbg_sel];

  // R3: a write-back is visible in the named register on the next cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned SW = SEL_W,
  localparam int unsigned OP_LSB = W - OP_W,
  localparam int unsigned A_LSB  = OP_LSB - SW,
  localparam int unsigned B_LSB  = A_LSB - SW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_we,
  input  logic [W-1:0]  mem_rdata,
  output logic          halted,
  output logic [SW-1:0] sel_a,
  output logic [SW-1:0] sel_b,
  input  logic [W-1:0]  val_a,
  input  logic [W-1:0]  val_b,
  output logic          wb_en,
  output logic [SW-1:0] wb_sel,
  output logic [W-1:0]  wb_data
);
  step_e          state;
  logic [W-1:0]   pc;
  logic [W-1:0]   ir;
  logic [OP_W-1:0] ir_op, fetch_op;
  logic [W-1:0]   rel_addr;

  assign ir_op    = ir[W-1:OP_LSB];
  assign fetch_op = mem_rdata[W-1:OP_LSB];
  assign sel_a    = ir[A_LSB +: SW];
  assign sel_b    = ir[B_LSB +: SW];
  assign rel_addr = pc + {{(W-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
    end else begin
      unique case (state)
        S_FETCH: begin
          pc    <= pc + 1'b1;
          state <= S_DECODE;
        end
        S_DECODE: begin
          ir <= mem_rdata;
          case (fetch_op)
            OP_LOAD, OP_STORE, OP_IMM, OP_PCREL: state <= S_MEM;
            OP_HALT:                             state <= S_HALT;
            default:                             state <= S_FETCH;
          endcase
        end
        S_MEM: begin
          if (ir_op == OP_IMM) pc <= pc + 1'b1;
          state <= (ir_op == OP_STORE) ? S_FETCH : S_WB;
        end
        S_WB:    state <= S_FETCH;
        default: state <= S_HALT;
      endcase
    end
  end

  always_comb begin
    mem_addr  = pc;
    mem_wdata = '0;
    mem_we    = 1'b0;
    if (state == S_MEM) begin
      case (ir_op)
        OP_LOAD:  mem_addr = val_a;
        OP_STORE: begin
          mem_addr  = val_b;
          mem_wdata = val_a;
          mem_we    = 1'b1;
        end
        OP_PCREL: mem_addr = rel_addr;
        default:  mem_addr = pc;
      endcase
    end
  end

  assign wb_en   = (state == S_WB);
  assign wb_sel  = (ir_op == OP_LOAD) ? sel_b : sel_a;
  assign wb_data = mem_rdata;
  assign halted  = (state == S_HALT);

  // R4: the write strobe never lasts more than one cycle
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R8: halt is sticky, the address is frozen and nothing is written
  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr) && !mem_we);
  // R9: each fetch moves the program counter by exactly one word
  a_r9_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH) |=> pc == $past(pc) + 1'b1);
  // R5: the inline literal is consumed, moving the program counter once more
  a_r5_imm_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MEM && ir_op == OP_IMM) |=> (pc == $past(pc) + 1'b1) && wb_en);
  // R7: an unlisted operation returns straight to fetch without touching memory
  a_r7_nop_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE && fetch_op[OP_W-1:OP_W-2] != 2'b11) |=> state == S_FETCH && !mem_we);
endmodule

// File: rtl/lsc_core.sv
module lsc_core
  import lsc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                mem_we,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                halted,
  input  logic [SEL_W-1:0]    dbg_sel,
  output logic [WORD_W-1:0]   dbg_data
);
  logic [SEL_W-1:0]  sel_a, sel_b, wb_sel;
  logic [WORD_W-1:0] val_a, val_b, wb_data;
  logic              wb_en;

  lsc_ctrl #(.W(WORD_W), .SW(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .halted(halted),
    .sel_a(sel_a), .sel_b(sel_b), .val_a(val_a), .val_b(val_b),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
  );

  lsc_regfile #(.W(WORD_W), .N(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wb_en), .wr_sel(wb_sel), .wr_data(wb_data),
    .rd_sel_a(sel_a), .rd_data_a(val_a),
    .rd_sel_b(sel_b), .rd_data_b(val_b),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );
endmodule

// File: tb/sim_lsc_core.sv
module sim_lsc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
  logic        mem_we, halted;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] mem [1024];
  int          n_cmp = 0, n_bad = 0, we_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  lsc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
    if (!rst_n) we_cnt <= 0; else if (mem_we) we_cnt <= we_cnt + 1;
    cyc <= cyc + 1;
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_cmp++; n_bad++;
    $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic [15:0] enc(logic [5:0] op, logic [2:0] a, logic [2:0] b, logic [3:0] lo);
    return {op, a, b, lo};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(int r, output logic [15:0] v);
    dbg_sel = 3'(r); #1; v = dbg_data;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic run_prog(string req);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (halted) break;
    end
    chk(req, 16'(halted), 16'd1);
  endtask

  initial begin
    logic [15:0] v, lit;
    int dst;
    // R2: reset state
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R2 halted", 16'(halted), 0);
    chk("R2 we", 16'(mem_we), 0);
    chk("R2 addr", mem_addr, 0);
    for (int r = 0; r < 8; r++) begin rd(r, v); chk("R2 reg", v, 0); end

    // R5: inline immediate into every register, one literal encodes halt
    clear_mem();
    for (int r = 0; r < 8; r++) begin
      mem[2*r]   = enc(6'b110010, 3'(r), 3'd0, 4'd0);
      mem[2*r+1] = (r == 3) ? 16'hFC00 : 16'hA000 + 16'(r * 16'h111);
    end
    mem[16] = 16'hFC00;
    run_prog("R5 halt reached");
    for (int r = 0; r < 8; r++) begin
      rd(r, v);
      chk("R5 literal", v, (r == 3) ? 16'hFC00 : 16'hA000 + 16'(r * 16'h111));
    end
    // R8: frozen after halt, address is the word after the halt
    chk("R8 addr", mem_addr, 16'd17);
    repeat (20) @(negedge clk);
    chk("R8 halted", 16'(halted), 1);
    chk("R8 addr hold", mem_addr, 16'd17);
    chk("R8 no write", 16'(we_cnt), 0);

    // R3, R1: load over every register pair, unused bits set
    for (int a = 0; a < 8; a++) for (int b = 0; b < 8; b++) begin
      clear_mem();
      mem[0] = enc(6'b110010, 3'(a), 3'd0, 4'd0);
      mem[1] = 16'h0100 + 16'(a*8+b);
      mem[2] = enc(6'b110000, 3'(a), 3'(b), 4'hF);
      mem[3] = 16'hFC00;
      mem[16'h100 + a*8+b] = 16'h3000 + 16'((a*8+b) * 16'h51);
      run_prog("R3 halt");
      for (int r = 0; r < 8; r++) begin
        rd(r, v);
        if (r == b)      chk("R3 loaded", v, 16'h3000 + 16'((a*8+b) * 16'h51));
        else if (r == a) chk("R3 addr kept", v, 16'h0100 + 16'(a*8+b));
        else             chk("R1 untouched", v, 0);
      end
    end

    // R2: reset clears registers after activity
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int r = 0; r < 8; r++) begin rd(r, v); chk("R2 clear", v, 0); end
    chk("R2 addr", mem_addr, 0);

    // R4: store over every register pair
    for (int a = 0; a < 8; a++) for (int b = 0; b < 8; b++) begin
      clear_mem();
      mem[0] = enc(6'b110010, 3'(a), 3'd0, 4'd0);
      mem[1] = 16'hC000 ^ 16'((a*8+b) * 16'h123);
      mem[2] = enc(6'b110010, 3'(b), 3'd0, 4'd0);
      mem[3] = 16'h0200 + 16'(a*8+b);
      mem[4] = enc(6'b110001, 3'(a), 3'(b), 4'h9);
      mem[5] = 16'hFC00;
      run_prog("R4 halt");
      chk("R4 data", mem[16'h200 + a*8+b],
          (a == b) ? 16'h0200 + 16'(a*8+b) : 16'hC000 ^ 16'((a*8+b) * 16'h123));
      chk("R4 neighbour", mem[16'h201 + a*8+b], 0);
      chk("R4 one strobe", 16'(we_cnt), 1);
    end

    // R6, R7: every PC-relative offset; NOP padding before the load
    for (int off = -64; off < 64; off++) begin
      clear_mem();
      for (int i = 0; i < 100; i++) mem[i] = 16'(i);
      for (int i = 102; i < 200; i++) mem[i] = 16'h4000 | 16'(i);
      dst = (off + 64) % 8;
      mem[100] = {6'b110011, 3'(dst), 7'(off)};
      mem[101] = 16'hFC00;
      lit = mem[101 + off];
      run_prog("R7 nops pass");
      rd(dst, v);
      chk("R6 pcrel", v, lit);
      chk("R9 halt addr", mem_addr, 16'd102);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule